// File: doc/BRIEF.md
# Four-Bit Arithmetic/Logic Unit with Hexadecimal Readout

This block has no clock and no state. It takes two unsigned four-bit operands and a two-bit operation code. It produces a five-bit result, which is the sum, the bitwise AND or the bitwise OR of the operands. For a sum, the carry out of the top stage becomes bit 4 of the result. For a logic operation, the result is zero-extended. The sum comes from a chain of full-adder cells, in which each carry ripples into the next stage.

The same result drives a two-digit seven-segment readout in hexadecimal. The lower digit shows bits 3:0. The upper digit shows bit 4 padded with zeros, so it can only show 0 or 1. Every segment line is active-low, and the decimal points are held dark. The operand width is a parameter. The digit count and the result width are derived from it.

Because the block has no state, the house-style state machine does not apply. The operation code is still an enumerated type, decoded with a `unique case`. Its four named values are ADD (00), AND (01), OR (10) and ZERO (11).

Top module: `alu_hex_top`

## Requirements
- R1: With op_sel = 00, result equals opnd_a + opnd_b as a 5-bit value, and the carry out is in bit 4. The largest value is 0x1E.
- R2: With op_sel = 01, result[3:0] = opnd_a & opnd_b and result[4] = 0.
- R3: With op_sel = 10, result[3:0] = opnd_a | opnd_b and result[4] = 0.
- R4: With op_sel = 11, result is 0 for every pair of operands.
- R5: digit_segs[7:0] drives the lower digit for result[3:0]. Bit 0 is segment a, through bit 6 for segment g, and bit 7 is the decimal point. Each segment bit is the inverse of its active-high glyph. The active-high glyphs for digits 0 through F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, so B shows as lowercase b and D as lowercase d.
- R6: digit_segs[15:8] drives the upper digit, using the same encoding, for the nibble {000, result[4]}. It is therefore 0xC0 (glyph 0) or 0xF9 (glyph 1), and nothing else.
- R7: Both decimal point bits, digit_segs[7] and digit_segs[15], are 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | DATA_W (4) | First unsigned operand |
| opnd_b | input | DATA_W (4) | Second unsigned operand |
| op_sel | input | 2 | Operation code: 00 add, 01 AND, 10 OR, 11 zero |
| result | output | DATA_W+1 (5) | Selected result, with the carry or zero extension in the top bit |
| digit_segs | output | 8*DIGITS (16) | Active-low segments for each digit, lower digit in the low byte |

## Verification
The bench builds the block with the default DATA_W of 4, which gives a five-bit result and two digits. With only 1024 input combinations, the bench can walk all of them. Every full-adder carry chain is therefore exercised, including the chain that reaches 0x1E. Every glyph is shown on the lower digit, and both glyphs appear on the upper digit. The ZERO code is also checked against every operand pair.

// File: rtl/alu_hex_pkg.sv
package alu_hex_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_AND  = 2'b01,
        OP_OR   = 2'b10,
        OP_ZERO = 2'b11
    } alu_op_e;

    localparam int SEG_W    = 8;
    localparam int NIBBLE_W = 4;

    // Active-high glyph, bit 0 = segment a ... bit 6 = segment g.
    function automatic logic [6:0] glyph_on(input logic [3:0] nib);
        logic [6:0] g;
        unique case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            4'hF: g = 7'h71;
            default: g = 7'h00;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    assign half = a ^ b;
    assign s    = half ^ ci;
    assign co   = (a & b) | (half & ci);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        alu_fa_cell u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    assign cout = carry[W];
endmodule

// File: rtl/alu_hex_digit.sv
module alu_hex_digit
    import alu_hex_pkg::*;
(
    input  logic [NIBBLE_W-1:0] nib,
    output logic [SEG_W-1:0]    segs_n
);
    logic [6:0] lit;

    always_comb begin
        lit    = glyph_on(nib);
        segs_n = {1'b1, ~lit};   // decimal point dark, segments active-low
    end
endmodule

// File: rtl/alu_hex_top.sv
module alu_hex_top
    import alu_hex_pkg::*;
#(
    parameter  int DATA_W = 4,
    localparam int RES_W  = DATA_W + 1,
    localparam int DIGITS = (RES_W + NIBBLE_W - 1) / NIBBLE_W
) (
    input  logic [DATA_W-1:0]      opnd_a,
    input  logic [DATA_W-1:0]      opnd_b,
    input  logic [1:0]             op_sel,
    output logic [RES_W-1:0]       result,
    output logic [DIGITS*SEG_W-1:0] digit_segs
);
    localparam int PAD_W = DIGITS * NIBBLE_W;

    logic [DATA_W-1:0] add_sum;
    logic              add_carry;
    logic [PAD_W-1:0]  res_pad;
    alu_op_e           op;

    alu_ripple_adder #(.W(DATA_W)) u_add (
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (1'b0),
        .sum  (add_sum),
        .cout (add_carry)
    );

    assign op = alu_op_e'(op_sel);

    always_comb begin
        result = '0;
        unique case (op)
            OP_ADD:  result = {add_carry, add_sum};
            OP_AND:  result = {1'b0, opnd_a & opnd_b};
            OP_OR:   result = {1'b0, opnd_a | opnd_b};
            OP_ZERO: result = '0;
            default: result = '0;
        endcase
    end

    assign res_pad = PAD_W'(result);

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        alu_hex_digit u_dig (
            .nib    (res_pad[d*NIBBLE_W +: NIBBLE_W]),
            .segs_n (digit_segs[d*SEG_W +: SEG_W])
        );
    end
endmodule

// File: rtl/alu_hex_chk.sv
module alu_hex_chk #(
    parameter int DATA_W = 4,
    parameter int RES_W  = DATA_W + 1,
    parameter int DIGITS = 2
) (
    input logic [DATA_W-1:0]    opnd_a,
    input logic [DATA_W-1:0]    opnd_b,
    input logic [1:0]           op_sel,
    input logic [RES_W-1:0]     result,
    input logic [DIGITS*8-1:0]  digit_segs
);
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (op_sel == 2'b00) begin
                p_add_r1: assert (result == RES_W'(opnd_a) + RES_W'(opnd_b))
                    else $error("R1 sum mismatch");
            end
            if (op_sel == 2'b01) begin
                p_and_r2: assert (result == {1'b0, opnd_a & opnd_b})
                    else $error("R2 AND mismatch");
            end
            if (op_sel == 2'b10) begin
                p_or_r3: assert (result == {1'b0, opnd_a | opnd_b})
                    else $error("R3 OR mismatch");
            end
            if (op_sel == 2'b11) begin
                p_zero_r4: assert (result == '0)
                    else $error("R4 zero code mismatch");
            end
            p_top_digit_r6: assert (digit_segs[DIGITS*8-1 -: 8] == 8'hC0 ||
                                    digit_segs[DIGITS*8-1 -: 8] == 8'hF9)
                else $error("R6 upper digit glyph out of range");
            for (int d = 0; d < DIGITS; d++) begin
                p_dp_dark_r7: assert (digit_segs[d*8+7] == 1'b1)
                    else $error("R7 decimal point lit");
            end
        end
    end
endmodule

bind alu_hex_top alu_hex_chk #(
    .DATA_W (DATA_W),
    .RES_W  (RES_W),
    .DIGITS (DIGITS)
) u_chk (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_sel     (op_sel),
    .result     (result),
    .digit_segs (digit_segs)
);

// File: tb/sim_alu_hex_top.sv
`timescale 1ns/1ps
module sim_alu_hex_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opnd_a, opnd_b;
    logic [1:0] op_sel;
    logic [4:0] result;
    logic [15:0] digit_segs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu_hex_top u0 (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .op_sel     (op_sel),
        .result     (result),
        .digit_segs (digit_segs)
    );

    // Active-high glyphs as stated in R5
    localparam logic [6:0] GLY [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

    // {op[1:0], a[3:0], b[3:0], expected result[4:0]}
    localparam logic [14:0] VEC [13] = '{
        {2'b00, 4'hF, 4'hF, 5'h1E},
        {2'b00, 4'h0, 4'h0, 5'h00},
        {2'b00, 4'h8, 4'h8, 5'h10},
        {2'b00, 4'h7, 4'h8, 5'h0F},
        {2'b00, 4'h5, 4'hC, 5'h11},
        {2'b01, 4'hF, 4'hA, 5'h0A},
        {2'b01, 4'h5, 4'hA, 5'h00},
        {2'b01, 4'hC, 4'h6, 5'h04},
        {2'b10, 4'h5, 4'hA, 5'h0F},
        {2'b10, 4'h0, 4'h0, 5'h00},
        {2'b10, 4'h3, 4'h8, 5'h0B},
        {2'b11, 4'hF, 4'hF, 5'h00},
        {2'b11, 4'h1, 4'h2, 5'h00}};

    function automatic logic [4:0] model_res(input logic [1:0] op,
                                             input logic [3:0] a,
                                             input logic [3:0] b);
        case (op)
            2'b00:   return {1'b0, a} + {1'b0, b};
            2'b01:   return {1'b0, a & b};
            2'b10:   return {1'b0, a | b};
            default: return 5'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_seg(input logic [3:0] nib);
        return {1'b1, ~GLY[nib]};
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    task automatic check_all(input string tag, input logic [4:0] exp_res);
        check({tag, " result"}, 16'(result), 16'(exp_res));
        check("R5 lower digit", 16'(digit_segs[7:0]), 16'(model_seg(exp_res[3:0])));
        check("R6 upper digit", 16'(digit_segs[15:8]), 16'(model_seg({3'b000, exp_res[4]})));
        check("R7 decimal points", 16'({digit_segs[15], digit_segs[7]}), 16'h3);
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1 add";
            2'b01:   return "R2 and";
            2'b10:   return "R3 or";
            default: return "R4 zero";
        endcase
    endfunction

    initial begin
        op_sel = 2'b00; opnd_a = 4'h0; opnd_b = 4'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // state after reset with idle inputs: "00" shown
        check("R5 reset lower digit", 16'(digit_segs[7:0]), 16'h00C0);
        check("R6 reset upper digit", 16'(digit_segs[15:8]), 16'h00C0);
        check("R1 reset result", 16'(result), 16'h0000);

        // table walk
        for (int i = 0; i < 13; i++) begin
            apply(VEC[i][14:13], VEC[i][12:9], VEC[i][8:5]);
            check_all(op_tag(VEC[i][14:13]), VEC[i][4:0]);
        end

        // exhaustive sweep of every code and operand pair
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    apply(2'(op), 4'(a), 4'(b));
                    check_all(op_tag(2'(op)), model_res(2'(op), 4'(a), 4'(b)));
                end
            end
        end

        // corner cases: lowercase glyphs and upper digit showing 1
        apply(2'b10, 4'hB, 4'h0);
        check("R5 glyph b", 16'(digit_segs[7:0]), 16'h0083);
        apply(2'b10, 4'hD, 4'h0);
        check("R5 glyph d", 16'(digit_segs[7:0]), 16'h00A1);
        apply(2'b00, 4'hF, 4'hF);
        check("R6 upper digit one", 16'(digit_segs[15:8]), 16'h00F9);
        check("R5 lower digit E", 16'(digit_segs[7:0]), 16'h0086);
        apply(2'b11, 4'hF, 4'hF);
        check("R4 zero after max sum", 16'(result), 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule